// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block holds the 32-bit interrupt status word of a card host controller. The lower sixteen bits record normal events and the upper sixteen record error events. Event pulses from the command and data engines latch into status only where a status-enable mask permits it. A second, independent signal-enable mask chooses which latched bits may assert the single interrupt line. Software acknowledges an event by writing a one to its status bit. A force write lets test software set error bits through the same status-enable gate.

A small card-status checker sits beside the status word. When a response arrives and the response type is flagged as one that carries card status, the checker ANDs the 32-bit response word with a card-status mask. If any bit survives, it raises the card-error status bit (bit 28). The checker is a two-state machine: `CK_IDLE` waits for a flagged response and moves to `CK_EVAL` on the strobe. `CK_EVAL` issues the card-error event if the masked word was non-zero, then returns to `CK_IDLE`, or stays in `CK_EVAL` when another flagged response arrives. The block has no command or data engine and no register bus decoder beyond a write strobe with a register select and a combinational read select.

Top module: `irq_status_ctrl`

## Requirements
- R1: Reset clears the status word, the status-enable mask, the signal-enable mask and the card-status mask, and drives `irq_o` low.
- R2: An event on `evt_i[b]` sets status bit b at the next clock edge only if status-enable bit b is 1. Otherwise the status bit stays 0.
- R3: A write with select 0 (status) clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an enabled event and a clear of the same status bit arrive in the same cycle, the bit ends up set.
- R5: `irq_o` is a register loaded with the OR over all bits of (status AND signal-enable). It follows a change of either one clock edge later. A latched status bit whose signal-enable bit is 0 does not assert `irq_o`.
- R6: A write with select 3 (force) sets status bits [31:16] where both the written bit and the status-enable bit are 1. It never sets bits [15:0], and it stores nothing: reading select 3 returns 0.
- R7: When `rsp_valid` and `rsp_chk_en` are both high at a clock edge and (`rsp_word` AND card-status mask) is non-zero, status bit 28 is set at the following edge, if status-enable bit 28 is 1.
- R8: No card-error event arises when `rsp_chk_en` is low (for example on an auto-stop response) or when the masked response word is zero.
- R9: Register selects are encoded as 0 status, 1 status-enable, 2 signal-enable, 3 force, 4 card-status mask. Writes to selects 1, 2 and 4 are read back unchanged through `rd_data` on the same select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data (combinational) |
| rsp_valid | input | 1 | Response word valid strobe |
| rsp_chk_en | input | 1 | Response type carries card status |
| rsp_word | input | 32 | Response card-status word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A status bit stuck at the wrong value appears on `rd_data` at the first read after the event or clear edge. It also appears on `irq_o` exactly one edge later whenever its signal-enable bit is set. A wrong mask value shows either in a readback or as a status bit that fails to latch, or latches when it should not, under a directed event pattern. A checker state machine that fires early, late or on an unflagged response is caught by reading bit 28 both after the strobe edge and after the one that follows it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [2:0] {
        SEL_STATUS    = 3'd0,
        SEL_STAT_EN   = 3'd1,
        SEL_SIG_EN    = 3'd2,
        SEL_FORCE     = 3'd3,
        SEL_CARD_MASK = 3'd4
    } reg_sel_e;

    typedef enum logic {
        CK_IDLE = 1'b0,
        CK_EVAL = 1'b1
    } ck_state_e;

endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
    import irq_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] stat_en,
    output logic [W-1:0] sig_en,
    output logic [W-1:0] card_mask
);

    localparam int NREG = 3;

    logic [NREG-1:0][W-1:0] regs_q;
    logic [NREG-1:0][2:0]   reg_code;

    assign reg_code[0] = SEL_STAT_EN;
    assign reg_code[1] = SEL_SIG_EN;
    assign reg_code[2] = SEL_CARD_MASK;

    // R9: one register per writable mask, each decoded from its select
    for (genvar g = 0; g < NREG; g++) begin : g_mask
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_sel == reg_code[g])) begin
                regs_q[g] <= wr_data;
            end
        end
    end

    assign stat_en   = regs_q[0];
    assign sig_en    = regs_q[1];
    assign card_mask = regs_q[2];

endmodule

// File: rtl/irq_card_check.sv
module irq_card_check
    import irq_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rsp_valid,
    input  logic         rsp_chk_en,
    input  logic [W-1:0] rsp_word,
    input  logic [W-1:0] card_mask,
    output logic         cerr_evt
);

    ck_state_e state_q, state_d;
    logic      hit_q;
    logic      strobe;

    assign strobe = rsp_valid && rsp_chk_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (strobe) begin
                hit_q <= |(rsp_word & card_mask);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CK_IDLE: if (strobe) state_d = CK_EVAL;
            CK_EVAL: state_d = strobe ? CK_EVAL : CK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cerr_evt = 1'b0;
        unique case (state_q)
            CK_IDLE: cerr_evt = 1'b0;
            CK_EVAL: cerr_evt = hit_q;
        endcase
    end

    // R7/R8: evaluation only follows a flagged response strobe
    a_r8_eval_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CK_EVAL) |-> $past(rsp_valid && rsp_chk_en));

    a_r7_evt_only_in_eval: assert property (@(posedge clk) disable iff (!rst_n)
        cerr_evt |-> (state_q == CK_EVAL));

endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
    parameter int W        = 32,
    parameter int NORM_W   = 16,
    parameter int CERR_IDX = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         cerr_evt,
    input  logic         force_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] stat_en,
    output logic [W-1:0] status
);

    localparam int          ERR_W    = W - NORM_W;
    localparam logic [W-1:0] ERR_MASK = {{ERR_W{1'b1}}, {NORM_W{1'b0}}};

    logic [W-1:0] cerr_vec;
    logic [W-1:0] force_vec;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] status_q;

    always_comb begin
        cerr_vec           = '0;
        cerr_vec[CERR_IDX] = cerr_evt;
    end

    // R6: force only reaches the error half
    assign force_vec = force_wr ? (wr_data & ERR_MASK) : '0;
    // R2: every source gated by the status-enable mask
    assign set_vec   = (evt_i | cerr_vec | force_vec) & stat_en;
    assign clr_vec   = clr_wr ? wr_data : '0;

    // R3/R4: write-one-to-clear, set dominates
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                status_q[b] <= 1'b0;
            end else if (set_vec[b]) begin
                status_q[b] <= 1'b1;
            end else if (clr_vec[b]) begin
                status_q[b] <= 1'b0;
            end
        end
    end

    assign status = status_q;

    a_r2_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(stat_en)) == '0));

    a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & $past(clr_vec & ~set_vec)) == '0));

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & $past(set_vec)) == $past(set_vec)));

    a_r6_low_half_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q[NORM_W-1:0] & ~$past(status_q[NORM_W-1:0])
          & ~$past(evt_i[NORM_W-1:0])) == '0));

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] sig_en,
    output logic         irq_o
);

    logic irq_q;

    // R5: registered OR of enabled pending bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status & sig_en);
        end
    end

    assign irq_o = irq_q;

    a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|status));

    a_r5_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sig_en) == '0) |-> !irq_o);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int W        = 32,
    parameter int NORM_W   = 16,
    parameter int CERR_IDX = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         rsp_valid,
    input  logic         rsp_chk_en,
    input  logic [W-1:0] rsp_word,
    output logic         irq_o
);

    logic [W-1:0] stat_en;
    logic [W-1:0] sig_en;
    logic [W-1:0] card_mask;
    logic [W-1:0] status;
    logic         cerr_evt;
    logic         force_wr;
    logic         clr_wr;

    assign force_wr = wr_en && (wr_sel == SEL_FORCE);
    assign clr_wr   = wr_en && (wr_sel == SEL_STATUS);

    irq_mask_regs #(.W(W)) i_masks (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .stat_en   (stat_en),
        .sig_en    (sig_en),
        .card_mask (card_mask)
    );

    irq_card_check #(.W(W)) i_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_valid  (rsp_valid),
        .rsp_chk_en (rsp_chk_en),
        .rsp_word   (rsp_word),
        .card_mask  (card_mask),
        .cerr_evt   (cerr_evt)
    );

    irq_status_core #(.W(W), .NORM_W(NORM_W), .CERR_IDX(CERR_IDX)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .cerr_evt (cerr_evt),
        .force_wr (force_wr),
        .clr_wr   (clr_wr),
        .wr_data  (wr_data),
        .stat_en  (stat_en),
        .status   (status)
    );

    irq_line_gen #(.W(W)) i_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .sig_en (sig_en),
        .irq_o  (irq_o)
    );

    // R9: read mux; force select has no storage behind it
    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_STATUS:    rd_data = status;
            SEL_STAT_EN:   rd_data = stat_en;
            SEL_SIG_EN:    rd_data = sig_en;
            SEL_CARD_MASK: rd_data = card_mask;
            default:       rd_data = '0;
        endcase
    end

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !irq_o);

endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        rsp_valid = 1'b0;
    logic        rsp_chk_en = 1'b0;
    logic [31:0] rsp_word = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .rsp_valid(rsp_valid),
        .rsp_chk_en(rsp_chk_en), .rsp_word(rsp_word), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt_i = e;
        tick();
        evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 5; s++) begin
            rd(s[2:0], v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(3'd1, 32'hA5A5_0F0F); rd(3'd1, v); chk("R9 stat_en readback", v, 32'hA5A5_0F0F);
        wr(3'd2, 32'h1234_5678); rd(3'd2, v); chk("R9 sig_en readback", v, 32'h1234_5678);
        wr(3'd4, 32'hDEAD_BEEF); rd(3'd4, v); chk("R9 card mask readback", v, 32'hDEAD_BEEF);
        wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] v;
        wr(3'd1, 32'h0000_00FF);
        pulse(32'h0000_0F0F);
        rd(3'd0, v); chk("R2 enabled events only", v, 32'h0000_000F);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0005);
        rd(3'd0, v); chk("R3 write-one clears", v, 32'h0000_000A);
    endtask

    task automatic t_race();
        logic [31:0] v;
        evt_i = 32'h0000_0002;
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h0000_000A;
        tick();
        evt_i = '0; wr_en = 1'b0; wr_data = '0;
        rd(3'd0, v); chk("R4 event beats clear", v, 32'h0000_0002);
    endtask

    task automatic t_irq();
        chk("R5 irq off with sig_en zero", {31'b0, irq_o}, 32'h0);
        wr(3'd2, 32'h0000_0002);
        chk("R5 irq not yet", {31'b0, irq_o}, 32'h0);
        tick();
        chk("R5 irq one edge later", {31'b0, irq_o}, 32'h1);
        wr(3'd0, 32'h0000_0002);
        chk("R5 irq held one edge", {31'b0, irq_o}, 32'h1);
        tick();
        chk("R5 irq drops after clear", {31'b0, irq_o}, 32'h0);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_force();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h00F0_00FF);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R6 force gated, upper only", v, 32'h00F0_0000);
        rd(3'd3, v); chk("R6 force not stored", v, 32'h0);
    endtask

    task automatic t_card();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'h1000_0000);
        wr(3'd4, 32'h0000_0080);
        rsp_valid = 1'b1; rsp_chk_en = 1'b1; rsp_word = 32'h0000_0081;
        tick();
        rsp_valid = 1'b0; rsp_chk_en = 1'b0; rsp_word = '0;
        rd(3'd0, v); chk("R7 card error not early", v, 32'h0);
        tick();
        rd(3'd0, v); chk("R7 card error raised", v, 32'h1000_0000);
    endtask

    task automatic t_card_neg();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        rsp_valid = 1'b1; rsp_chk_en = 1'b0; rsp_word = 32'h0000_0080;
        tick();
        rsp_valid = 1'b0; rsp_word = '0;
        tick(); tick();
        rd(3'd0, v); chk("R8 unflagged response ignored", v, 32'h0);
        rsp_valid = 1'b1; rsp_chk_en = 1'b1; rsp_word = 32'hFFFF_FF7F;
        tick();
        rsp_valid = 1'b0; rsp_chk_en = 1'b0; rsp_word = '0;
        tick(); tick();
        rd(3'd0, v); chk("R8 masked-out response ignored", v, 32'h0);
    endtask

    task automatic t_reset_again();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        t_reset();
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_masks();
        t_gating();
        t_w1c();
        t_race();
        t_irq();
        t_force();
        t_card();
        t_card_neg();
        t_reset_again();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule